// File: doc/BRIEF.md
# Bitmask Conversion Channel Sequencer

This block runs the command-mode side of a multichannel monitor. The host writes an 8-bit channel mask. Each later host read then moves to the next set bit of that mask, in ascending order, and wraps from the highest set bit back to the lowest. Every read returns one 16-bit result word, delivered as two bytes.

Channels that are not temperature channels go to the converter through a plain start/done handshake. The read stalls, with `busy` high, until the converter reports done. Temperature channels never start a conversion. They replay the latest result that the background (autonomous) cycle left on the `temp_res` inputs. While autonomous cycling is enabled, command mode cannot be entered, and any command mode already running is dropped.

Both data flows use valid/ready. A read request is taken only on a cycle where `req_valid` and `req_ready` are both high. An output byte is consumed only when `out_valid` and `out_ready` are both high. While the host holds `out_ready` low, the byte and `out_last` stay frozen. Command, converter and autonomous-mode pins are plain control signals.

Top module: `chan_sequencer`

## Requirements
- R1: After reset the mask is all zero, `cmd_active`, `busy`, `out_valid` and `conv_start` are low, `req_ready` is high, and the stored last word is 0x0000.
- R2: A `cmd_wr` pulse with `auto_en` low loads the mask, raises `cmd_active` on the next cycle, and makes the next read start from the lowest set bit.
- R3: In command mode, successive reads visit only the set mask bits, in ascending bit order, and wrap from the highest set bit to the lowest.
- R4: Bits 6 and 7 are temperature channels (sensor 0 is bit 6, sensor 1 is bit 7). Their reads raise no `conv_start` and return that sensor's `temp_alert` bit and `temp_res` field.
- R5: A read of any other channel raises `conv_start` for exactly one cycle with `conv_chan` equal to the bit index. `busy` stays high until `conv_done`, and the word is built from `conv_alert` and `conv_data` as seen on the `conv_done` cycle.
- R6: Word layout: bit 15 is the alert flag, bits 14..12 are the channel tag (the mask bit index), and bits 11..0 are the 12-bit result.
- R7: Each read yields two output bytes. The first is word bits 15..8 with `out_last` low; the second is bits 7..0 with `out_last` high. A byte and `out_last` stay stable while `out_valid` is high and `out_ready` is low.
- R8: `req_ready` drops when a read is accepted and comes back only after the low byte has been taken, so only one read is in flight at a time.
- R9: A read while the mask is zero, or while not in command mode, returns the last word again and starts no conversion.
- R10: While `auto_en` is high, `cmd_active` is forced low on the next cycle and a `cmd_wr` does not enter command mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_mask | input | 8 | Channel mask written with `cmd_wr` |
| auto_en | input | 1 | Autonomous cycling enabled |
| req_valid | input | 1 | Host read request |
| req_ready | output | 1 | Read request can be accepted |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Host takes output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Marks the low (second) byte |
| busy | output | 1 | Waiting on the converter |
| cmd_active | output | 1 | Command mode is active |
| conv_start | output | 1 | One-cycle conversion request |
| conv_chan | output | 3 | Channel to convert |
| conv_done | input | 1 | Conversion finished, data valid |
| conv_alert | input | 1 | Alert flag of the conversion |
| conv_data | input | 12 | Conversion result |
| temp_res | input | 24 | Latest background results, sensor 0 in bits 11..0 |
| temp_alert | input | 2 | Alert flags of the background results |

## Verification
The bench sweeps all 256 masks, varying converter latency and output back-pressure, and predicts each word from the mask alone.

- A design that skipped clear bits, or restarted at bit 0 instead of wrapping to the lowest set bit, would return a wrong tag.
- A design that converted temperature slots would show an extra conversion start.
- A design that ignored the pointer reset on a rewrite would continue mid-sequence.
- A zero mask must replay the previous word rather than zero or stale converter data.
- The autonomous interlock is exercised by writing while `auto_en` is high. A design that let that write through would report command mode and start a conversion on the next read.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int RES_W  = 12;
  localparam int TAG_W  = 3;
  localparam int WORD_W = 1 + TAG_W + RES_W;

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_SEND} seq_state_e;

  function automatic logic [WORD_W-1:0] pack_word(input logic alert,
                                                  input logic [TAG_W-1:0] tag,
                                                  input logic [RES_W-1:0] res);
    return {alert, tag, res};
  endfunction
endpackage

// File: rtl/seq_picker.sv
module seq_picker #(
  parameter int NCH = 8,
  localparam int TW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  input  logic [TW-1:0]  from,
  output logic           found,
  output logic [TW-1:0]  pick
);
  // circular search upward from 'from'; the nearest set bit wins
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = NCH - 1; k >= 0; k--) begin
      logic [TW-1:0] idx;
      idx = from + TW'(k);
      if (mask[idx]) begin
        found = 1'b1;
        pick  = idx;
      end
    end
  end
endmodule

// File: rtl/seq_serializer.sv
module seq_serializer #(
  parameter int WORD_W = 16,
  localparam int BYTE_W = WORD_W / 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  output logic              active,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_data,
  output logic              out_last
);
  logic [WORD_W-1:0] held_q;
  logic              full_q, lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= '0;
      full_q <= 1'b0;
      lo_q   <= 1'b0;
    end else if (load) begin
      held_q <= word;
      full_q <= 1'b1;
      lo_q   <= 1'b0;
    end else if (full_q && out_ready) begin
      if (!lo_q) lo_q <= 1'b1;
      else       full_q <= 1'b0;
    end
  end

  assign active    = full_q;
  assign out_valid = full_q;
  assign out_last  = lo_q;
  assign out_data  = lo_q ? held_q[BYTE_W-1:0] : held_q[WORD_W-1:BYTE_W];

  // R7: a stalled byte is held unchanged
  a_r7_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
endmodule

// File: rtl/chan_sequencer.sv
module chan_sequencer #(
  parameter int NCH       = 8,
  parameter int TEMP_BASE = 6,
  parameter int NTEMP     = 2,
  localparam int TW       = $clog2(NCH),
  localparam int RW       = seq_pkg::RES_W,
  localparam int WW       = seq_pkg::WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [NCH-1:0]    cmd_mask,
  input  logic              auto_en,
  input  logic              req_valid,
  output logic              req_ready,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [7:0]        out_data,
  output logic              out_last,
  output logic              busy,
  output logic              cmd_active,
  output logic              conv_start,
  output logic [TW-1:0]     conv_chan,
  input  logic              conv_done,
  input  logic              conv_alert,
  input  logic [RW-1:0]     conv_data,
  input  logic [NTEMP*RW-1:0] temp_res,
  input  logic [NTEMP-1:0]  temp_alert
);
  import seq_pkg::*;

  seq_state_e     state_q;
  logic [NCH-1:0] mask_q;
  logic [TW-1:0]  ptr_q, chan_q;
  logic           active_q;
  logic [WW-1:0]  last_q;
  logic           found, live, accept, need_conv, load, ser_active, cmd_take;
  logic [TW-1:0]  pick;
  logic [WW-1:0]  load_word, temp_word;
  logic [NTEMP-1:0] tmatch;
  logic [WW-1:0]  tword [NTEMP];

  seq_picker #(.NCH(NCH)) u_pick (
    .mask(mask_q), .from(ptr_q), .found(found), .pick(pick)
  );

  for (genvar t = 0; t < NTEMP; t++) begin : g_temp
    assign tmatch[t] = (pick == TW'(TEMP_BASE + t));
    assign tword[t]  = pack_word(temp_alert[t], pick, temp_res[t*RW +: RW]);
  end

  always_comb begin
    temp_word = '0;
    for (int t = 0; t < NTEMP; t++)
      if (tmatch[t]) temp_word = tword[t];
  end

  assign cmd_take  = cmd_wr && !auto_en;
  assign live      = active_q && found;
  assign accept    = req_valid && req_ready;
  assign need_conv = live && !(|tmatch);
  assign load      = (accept && !need_conv) || (state_q == ST_WAIT && conv_done);

  always_comb begin
    if (state_q == ST_WAIT) load_word = pack_word(conv_alert, chan_q, conv_data);
    else if (live)          load_word = temp_word;
    else                    load_word = last_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mask_q   <= '0;
      ptr_q    <= '0;
      chan_q   <= '0;
      active_q <= 1'b0;
      last_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) state_q <= need_conv ? ST_REQ : ST_SEND;
        ST_REQ:  state_q <= ST_WAIT;
        ST_WAIT: if (conv_done) state_q <= ST_SEND;
        default: if (!ser_active) state_q <= ST_IDLE;
      endcase
      if (accept && need_conv) chan_q <= pick;
      if (load) last_q <= load_word;
      if (auto_en)       active_q <= 1'b0;
      else if (cmd_wr)   active_q <= 1'b1;
      if (cmd_take) begin
        mask_q <= cmd_mask;
        ptr_q  <= '0;
      end else if (accept && live) begin
        ptr_q  <= pick + TW'(1);
      end
    end
  end

  seq_serializer #(.WORD_W(WW)) u_ser (
    .clk(clk), .rst_n(rst_n), .load(load), .word(load_word),
    .active(ser_active), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last)
  );

  assign req_ready  = (state_q == ST_IDLE);
  assign busy       = (state_q == ST_REQ) || (state_q == ST_WAIT);
  assign conv_start = (state_q == ST_REQ);
  assign conv_chan  = chan_q;
  assign cmd_active = active_q;

  // R10: autonomous cycling drops command mode
  a_r10_interlock: assert property (@(posedge clk) disable iff (!rst_n)
    auto_en |=> !cmd_active);
  // R2: an allowed write enters command mode
  a_r2_enter: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !auto_en |=> cmd_active);
  // R4: temperature slots never start the converter
  a_r4_temp_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> !(int'(conv_chan) >= TEMP_BASE && int'(conv_chan) < TEMP_BASE + NTEMP));
  // R5: the start is a single-cycle pulse followed by a busy wait
  a_r5_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |=> !conv_start && busy);
  // R5: busy holds until the converter reports done
  a_r5_busy_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !conv_done |=> busy);
  // R8: no new read while a word is still going out
  a_r8_single: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !req_ready);
endmodule

// File: tb/sim_chan_sequencer.sv
module sim_chan_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_wr = 1'b0;
  logic [7:0] cmd_mask = '0;
  logic auto_en = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic out_valid;
  logic out_ready = 1'b1;
  logic [7:0] out_data;
  logic out_last;
  logic busy, cmd_active, conv_start;
  logic [2:0] conv_chan;
  logic conv_done = 1'b0;
  logic conv_alert = 1'b0;
  logic [11:0] conv_data = '0;
  logic [11:0] tres [2];
  logic [1:0] talert = '0;

  int tests = 0, fails = 0, starts = 0, exp_starts = 0, delay = 0;
  bit stall = 0;
  logic [15:0] last_exp = '0;

  always #5 clk = ~clk;

  chan_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_mask(cmd_mask),
    .auto_en(auto_en), .req_valid(req_valid), .req_ready(req_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .busy(busy), .cmd_active(cmd_active),
    .conv_start(conv_start), .conv_chan(conv_chan), .conv_done(conv_done),
    .conv_alert(conv_alert), .conv_data(conv_data),
    .temp_res({tres[1], tres[0]}), .temp_alert(talert)
  );

  function automatic logic [11:0] conv_val(int ch, int n);
    return 12'((ch * 293 + n * 17 + 5) & 32'hfff);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // converter model
  initial begin
    forever begin
      @(negedge clk);
      if (conv_start) begin
        int ch, n;
        ch = int'(conv_chan);
        n = starts;
        starts++;
        chk("R5 busy at start", 16'(busy), 16'd1);
        repeat (delay) @(negedge clk);
        @(negedge clk);
        conv_data = conv_val(ch, n);
        conv_alert = n[0];
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
      end
    end
  end

  task automatic do_read(output logic [15:0] w);
    req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8 ready low after accept", 16'(req_ready), 16'd0);
    while (!out_valid) @(negedge clk);
    if (stall) begin
      logic [7:0] hold;
      out_ready = 1'b0;
      hold = out_data;
      repeat (2) @(negedge clk);
      chk("R7 stalled byte stable", {7'd0, out_valid, out_data}, {7'd0, 1'b1, hold});
      out_ready = 1'b1;
    end
    w[15:8] = out_data;
    chk("R7 first byte not last", 16'(out_last), 16'd0);
    @(negedge clk);
    while (!out_valid) @(negedge clk);
    w[7:0] = out_data;
    chk("R7 second byte last", 16'(out_last), 16'd1);
    @(negedge clk);
  endtask

  task automatic write_mask(logic [7:0] m);
    cmd_mask = m;
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
  endtask

  // expected word for bit b; updates the expected start count
  task automatic expect_word(int b, output logic [15:0] e, output bit conv);
    if (b >= 6) begin
      e = {talert[b-6], 3'(b), tres[b-6]};
      conv = 0;
    end else begin
      e = {exp_starts[0], 3'(b), conv_val(b, exp_starts)};
      exp_starts++;
      conv = 1;
    end
  endtask

  initial begin
    tres[0] = '0;
    tres[1] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset req_ready", 16'(req_ready), 16'd1);
    chk("R1 reset idle outputs", {12'd0, out_valid, busy, cmd_active, conv_start}, 16'd0);
    begin
      logic [15:0] w;
      do_read(w);
      chk("R1 R9 first read returns zero word", w, 16'h0000);
      chk("R9 no conversion before command mode", 16'(starts), 16'd0);
    end

    for (int m = 0; m < 256; m++) begin
      int list [8];
      int n;
      logic [15:0] w, e;
      bit cv;
      int s0;
      n = 0;
      for (int b = 0; b < 8; b++) if (m[b]) begin list[n] = b; n++; end
      tres[0] = 12'((m * 3 + 1) & 32'hfff);
      tres[1] = 12'((m * 7 + 2) & 32'hfff);
      talert = m[1:0];
      delay = m % 4;
      stall = (m % 3 == 0);
      write_mask(8'(m));
      chk("R2 command mode entered", 16'(cmd_active), 16'd1);
      if (n == 0) begin
        for (int r = 0; r < 2; r++) begin
          s0 = starts;
          do_read(w);
          chk("R9 zero mask replays last word", w, last_exp);
          chk("R9 zero mask starts nothing", 16'(starts - s0), 16'd0);
        end
      end else begin
        for (int r = 0; r < n + 2; r++) begin
          s0 = starts;
          expect_word(list[r % n], e, cv);
          do_read(w);
          chk("R3 R6 ordered and wrapped word", w, e);
          if (cv) chk("R5 one conversion started", 16'(starts - s0), 16'd1);
          else    chk("R4 temperature slot starts nothing", 16'(starts - s0), 16'd0);
          last_exp = e;
        end
        write_mask(8'(m));
        s0 = starts;
        expect_word(list[0], e, cv);
        do_read(w);
        chk("R2 rewrite restarts at lowest bit", w, e);
        last_exp = e;
      end
    end

    begin
      logic [15:0] w;
      bit cv;
      int s0;
      auto_en = 1'b1;
      repeat (2) @(negedge clk);
      chk("R10 autonomous mode clears command mode", 16'(cmd_active), 16'd0);
      write_mask(8'h01);
      @(negedge clk);
      chk("R10 write refused while autonomous", 16'(cmd_active), 16'd0);
      auto_en = 1'b0;
      @(negedge clk);
      s0 = starts;
      do_read(w);
      chk("R10 R9 refused write: last word replayed", w, last_exp);
      chk("R10 refused write starts nothing", 16'(starts - s0), 16'd0);
      write_mask(8'h01);
      chk("R2 write accepted after autonomous off", 16'(cmd_active), 16'd1);
      begin
        logic [15:0] e;
        expect_word(0, e, cv);
        do_read(w);
        chk("R2 R5 channel 0 converted", w, e);
      end
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule